// File: doc/BRIEF.md
# Multi-Slot Audio Frame Serializer (Transmit, Clock Master)

This block turns parallel audio samples into a serial bit stream with a matching word-select (frame sync) line. It is used as the transmit half of an audio port that drives the bit clock. A clock divider elsewhere supplies a one-cycle bit strobe, `bckEn`, in the system clock domain. Every registered output of this block moves only on that strobe. Samples come from a show-ahead FIFO: the word at `fifoData` is valid whenever `fifoEmpty` is low. `fifoPop` is a combinational request, and the FIFO acts on it at the same clock edge.

A frame holds `cfgSlots` slots, with 2 or more slots. Each slot is `cfgSlotWidth` bit periods long. A slot carries one sample of `cfgSampleWidth` bits, taken from the low bits of the FIFO word, and the sample is sent at the start of the slot. Four framing styles are available:
- Standard: data trails word-select by one bit period.
- Left-justified.
- Short pulse.
- Long pulse.

The sync pulse length depends on the framing style. The opening level of word-select depends on the slot count. A slot mask, a mono option and a bit-order option shape the payload.

Configuration is sampled only when a frame begins. Dropping `runEn` lets the current frame finish before the block goes idle.

Top module: `tdm_frame_serializer`

## Requirements
- R1: After reset, `wsOut`, `sdOut`, `fifoPop` and `underflow` are all 0. The latched configuration is then two slots, so word-select idles low.
- R2: For `cfgFormat` 0 (standard) and 1 (left-justified), word-select holds its opening level for the first slots×slotWidth/2 bit periods of the frame, then the other level for the rest of the frame.
- R3: For `cfgFormat` 2 (short pulse), word-select holds its opening level for exactly the first bit period of the frame.
- R4: For `cfgFormat` 3 (long pulse), word-select holds its opening level for the first slotWidth bit periods of the frame.
- R5: The opening level, which is also the idle level, is high when the frame has more than two slots and low when it has exactly two.
- R6: Only for `cfgFormat` 0, `sdOut` carries the bit of the previous bit period, so data lags word-select by one bit period. In the other formats, data is aligned with word-select.
- R7: Within a slot, bit periods below `cfgSampleWidth` carry the sample, taken from the low `cfgSampleWidth` bits of `fifoData`. The remaining bit periods of the slot are 0.
- R8: With `cfgLsbFirst` = 0, the sample is sent from its most significant bit down. With `cfgLsbFirst` = 1, it is sent from bit 0 up.
- R9: Bit n of `cfgChanMask` enables slot n. A disabled slot sends zeros and does not pop the FIFO.
- R10: With `cfgMono` = 1, only slot 0 pops the FIFO. Every other enabled slot of the same frame repeats the sample of slot 0.
- R11: When an enabled slot that needs a sample begins while `fifoEmpty` is high, the slot sends zeros and there is no pop. `underflow` then rises and stays high until reset.
- R12: Configuration inputs are sampled only at the bit strobe that starts a frame. A change in the middle of a frame has no effect until the next frame.
- R13: When `runEn` is low at the last bit period of a frame, the frame completes and the block goes idle. While idle, word-select sits at the opening level and data is 0, apart from the one trailing bit in format 0.
- R14: `wsOut` and `sdOut` change only at clock edges where `bckEn` is high. `fifoPop` is high only while `bckEn` is high and a frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bckEn | input | 1 | One-cycle strobe per serial bit period |
| runEn | input | 1 | Run request; sampled at frame boundaries |
| cfgSlots | input | $clog2(MAX_SLOTS+1) | Slots per frame (2..MAX_SLOTS) |
| cfgSlotWidth | input | $clog2(MAX_WIDTH+1) | Bit periods per slot (2..MAX_WIDTH) |
| cfgSampleWidth | input | $clog2(MAX_WIDTH+1) | Sample bits per slot (1..slot width) |
| cfgFormat | input | 2 | 0 standard, 1 left-justified, 2 short pulse, 3 long pulse |
| cfgChanMask | input | MAX_SLOTS | Per-slot enable, bit n for slot n |
| cfgMono | input | 1 | Repeat the slot-0 sample in all enabled slots |
| cfgLsbFirst | input | 1 | 1 sends bit 0 first |
| fifoData | input | MAX_WIDTH | Head word of the sample FIFO, sample right-aligned |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoPop | output | 1 | Consume the head word at this edge |
| wsOut | output | 1 | Word-select / frame sync |
| sdOut | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a sample was needed while the FIFO was empty |

## Verification
A slip in the bit or slot counters shows as a word-select edge that lands on the wrong bit period. It also shows as a data bit that moves into the neighbouring slot. Both appear within the first frame after the slip, at the first position where the two differ.

A wrong latched configuration leaves the current frame intact and shows in the next one as a wrong pulse length or opening level. A wrong pop decision shows as a pop count that differs from the model at the end of the run. After that, every later sample is also shifted by one slot.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  // Framing style; the value is the port encoding of cfgFormat.
  typedef enum logic [1:0] {
    FMT_STD       = 2'd0,
    FMT_LEFT      = 2'd1,
    FMT_PCM_SHORT = 2'd2,
    FMT_PCM_LONG  = 2'd3
  } fmt_e;

  // Strobes from the frame control to the datapath.
  typedef struct packed {
    logic shift;      // bit strobe, running or idle
    logic emit;       // bit strobe while a frame runs
    logic slotStart;  // first bit period of a slot
    logic slotOn;     // current slot enabled by the mask
    logic firstSlot;  // current slot is slot 0
  } strobe_t;

endpackage

// File: rtl/tdm_ser_ctrl.sv
module tdm_ser_ctrl
  import tdm_ser_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WIDTH = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               bckEn,
  input  logic                               runEn,
  input  logic [$clog2(MAX_SLOTS+1)-1:0]     cfgSlots,
  input  logic [$clog2(MAX_WIDTH+1)-1:0]     cfgSlotWidth,
  input  logic [$clog2(MAX_WIDTH+1)-1:0]     cfgSampleWidth,
  input  logic [1:0]                         cfgFormat,
  input  logic [MAX_SLOTS-1:0]               cfgChanMask,
  input  logic                               cfgMono,
  input  logic                               cfgLsbFirst,
  output strobe_t                            strb,
  output logic [$clog2(MAX_WIDTH)-1:0]       bitIdx,
  output logic [$clog2(MAX_WIDTH+1)-1:0]     smpWidthQ,
  output fmt_e                               fmtQ,
  output logic                               monoQ,
  output logic                               lsbFirstQ,
  output logic                               wsOut,
  output logic                               running
);

  localparam int CNT_W  = $clog2(MAX_SLOTS + 1);
  localparam int SW_W   = $clog2(MAX_WIDTH + 1);
  localparam int BIT_W  = $clog2(MAX_WIDTH);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int POS_W  = $clog2(MAX_SLOTS * MAX_WIDTH + 1);

  // Latched frame configuration.
  logic [CNT_W-1:0]     slotsQ;
  logic [SW_W-1:0]      slotWidthQ;
  logic [MAX_SLOTS-1:0] maskQ;
  logic [POS_W-1:0]     frameBitsQ;
  logic [POS_W-1:0]     wsWidthQ;

  // Position inside the frame.
  logic                 runningQ;
  logic [BIT_W-1:0]     bitQ;
  logic [SLOT_W-1:0]    slotQ;
  logic [POS_W-1:0]     posQ;
  logic                 wsQ;

  logic [POS_W-1:0]     nextFrameBits;
  logic [POS_W-1:0]     nextWsWidth;
  logic                 lastBit;
  logic                 lastPos;
  logic                 openLvl;
  logic                 loadCfg;

  // Frame length and sync width for the configuration being offered.
  always_comb begin
    nextFrameBits = POS_W'(cfgSlots) * POS_W'(cfgSlotWidth);
    case (fmt_e'(cfgFormat))
      FMT_PCM_SHORT: nextWsWidth = POS_W'(1);
      FMT_PCM_LONG:  nextWsWidth = POS_W'(cfgSlotWidth);
      default:       nextWsWidth = nextFrameBits >> 1;
    endcase
  end

  assign lastBit = (SW_W'(bitQ) == slotWidthQ - SW_W'(1));
  assign lastPos = (posQ == frameBitsQ - POS_W'(1));
  assign openLvl = (slotsQ > CNT_W'(2));
  assign loadCfg = bckEn && runEn && (!runningQ || lastPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotsQ     <= CNT_W'(2);
      slotWidthQ <= SW_W'(MAX_WIDTH);
      smpWidthQ  <= SW_W'(MAX_WIDTH);
      fmtQ       <= FMT_STD;
      maskQ      <= '1;
      monoQ      <= 1'b0;
      lsbFirstQ  <= 1'b0;
      frameBitsQ <= POS_W'(2 * MAX_WIDTH);
      wsWidthQ   <= POS_W'(MAX_WIDTH);
    end else if (loadCfg) begin
      slotsQ     <= cfgSlots;
      slotWidthQ <= cfgSlotWidth;
      smpWidthQ  <= cfgSampleWidth;
      fmtQ       <= fmt_e'(cfgFormat);
      maskQ      <= cfgChanMask;
      monoQ      <= cfgMono;
      lsbFirstQ  <= cfgLsbFirst;
      frameBitsQ <= nextFrameBits;
      wsWidthQ   <= nextWsWidth;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runningQ <= 1'b0;
      bitQ     <= '0;
      slotQ    <= '0;
      posQ     <= '0;
      wsQ      <= 1'b0;
    end else if (bckEn) begin
      if (runningQ) begin
        wsQ <= (posQ < wsWidthQ) ? openLvl : !openLvl;
        if (lastPos) begin
          bitQ  <= '0;
          slotQ <= '0;
          posQ  <= '0;
          if (!runEn) runningQ <= 1'b0;
        end else if (lastBit) begin
          bitQ  <= '0;
          slotQ <= slotQ + 1'b1;
          posQ  <= posQ + 1'b1;
        end else begin
          bitQ  <= bitQ + 1'b1;
          posQ  <= posQ + 1'b1;
        end
      end else begin
        wsQ <= openLvl;
        if (runEn) begin
          runningQ <= 1'b1;
          bitQ     <= '0;
          slotQ    <= '0;
          posQ     <= '0;
        end
      end
    end
  end

  always_comb begin
    strb.shift     = bckEn;
    strb.emit      = bckEn && runningQ;
    strb.slotStart = (bitQ == '0);
    strb.slotOn    = maskQ[slotQ];
    strb.firstSlot = (slotQ == '0);
  end

  assign bitIdx  = bitQ;
  assign wsOut   = wsQ;
  assign running = runningQ;

endmodule

// File: rtl/tdm_ser_dp.sv
module tdm_ser_dp
  import tdm_ser_pkg::*;
#(
  parameter int MAX_WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [$clog2(MAX_WIDTH)-1:0]   bitIdx,
  input  logic [$clog2(MAX_WIDTH+1)-1:0] smpWidthQ,
  input  fmt_e                           fmtQ,
  input  logic                           monoQ,
  input  logic                           lsbFirstQ,
  input  logic [MAX_WIDTH-1:0]           fifoData,
  input  logic                           fifoEmpty,
  output logic                           fifoPop,
  output logic                           sdOut,
  output logic                           underflow
);

  localparam int SW_W = $clog2(MAX_WIDTH + 1);

  logic [MAX_WIDTH-1:0] wordQ;
  logic [MAX_WIDTH-1:0] monoWordQ;
  logic [MAX_WIDTH-1:0] newWord;
  logic [MAX_WIDTH-1:0] curWord;
  logic [SW_W-1:0]      idx;
  logic                 inSample;
  logic                 selBit;
  logic                 rawBit;
  logic                 needFifo;
  logic                 rawQ;
  logic                 dlyQ;
  logic                 selDlyQ;
  logic                 underflowQ;

  // A slot wants a new FIFO word when it is enabled and not a mono repeat.
  assign needFifo = strb.emit && strb.slotStart && strb.slotOn &&
                    (!monoQ || strb.firstSlot);
  assign fifoPop  = needFifo && !fifoEmpty;

  always_comb begin
    if (!strb.slotOn)                  newWord = '0;
    else if (monoQ && !strb.firstSlot) newWord = monoWordQ;
    else if (fifoEmpty)                newWord = '0;
    else                               newWord = fifoData;
  end

  assign curWord  = strb.slotStart ? newWord : wordQ;
  assign inSample = (SW_W'(bitIdx) < smpWidthQ);
  assign idx      = lsbFirstQ ? SW_W'(bitIdx)
                              : smpWidthQ - SW_W'(1) - SW_W'(bitIdx);

  // Indexed pick of the outgoing bit from the held word.
  always_comb begin
    selBit = 1'b0;
    for (int i = 0; i < MAX_WIDTH; i++) begin
      if (idx == SW_W'(i)) selBit = curWord[i];
    end
  end

  assign rawBit = inSample && selBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ      <= '0;
      monoWordQ  <= '0;
      rawQ       <= 1'b0;
      dlyQ       <= 1'b0;
      selDlyQ    <= 1'b0;
      underflowQ <= 1'b0;
    end else if (strb.shift) begin
      dlyQ <= rawQ;
      if (strb.emit) begin
        rawQ    <= rawBit;
        selDlyQ <= (fmtQ == FMT_STD);
        if (strb.slotStart) begin
          wordQ <= newWord;
          if (strb.firstSlot) monoWordQ <= newWord;
        end
        if (needFifo && fifoEmpty) underflowQ <= 1'b1;
      end else begin
        rawQ <= 1'b0;
      end
    end
  end

  assign sdOut     = selDlyQ ? dlyQ : rawQ;
  assign underflow = underflowQ;

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
  import tdm_ser_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           bckEn,
  input  logic                           runEn,
  input  logic [$clog2(MAX_SLOTS+1)-1:0] cfgSlots,
  input  logic [$clog2(MAX_WIDTH+1)-1:0] cfgSlotWidth,
  input  logic [$clog2(MAX_WIDTH+1)-1:0] cfgSampleWidth,
  input  logic [1:0]                     cfgFormat,
  input  logic [MAX_SLOTS-1:0]           cfgChanMask,
  input  logic                           cfgMono,
  input  logic                           cfgLsbFirst,
  input  logic [MAX_WIDTH-1:0]           fifoData,
  input  logic                           fifoEmpty,
  output logic                           fifoPop,
  output logic                           wsOut,
  output logic                           sdOut,
  output logic                           underflow
);

  localparam int SW_W  = $clog2(MAX_WIDTH + 1);
  localparam int BIT_W = $clog2(MAX_WIDTH);

  strobe_t          strb;
  logic [BIT_W-1:0] bitIdx;
  logic [SW_W-1:0]  smpWidthQ;
  fmt_e             fmtQ;
  logic             monoQ;
  logic             lsbFirstQ;
  logic             frameRunning;

  tdm_ser_ctrl #(
    .MAX_SLOTS(MAX_SLOTS),
    .MAX_WIDTH(MAX_WIDTH)
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .bckEn         (bckEn),
    .runEn         (runEn),
    .cfgSlots      (cfgSlots),
    .cfgSlotWidth  (cfgSlotWidth),
    .cfgSampleWidth(cfgSampleWidth),
    .cfgFormat     (cfgFormat),
    .cfgChanMask   (cfgChanMask),
    .cfgMono       (cfgMono),
    .cfgLsbFirst   (cfgLsbFirst),
    .strb          (strb),
    .bitIdx        (bitIdx),
    .smpWidthQ     (smpWidthQ),
    .fmtQ          (fmtQ),
    .monoQ         (monoQ),
    .lsbFirstQ     (lsbFirstQ),
    .wsOut         (wsOut),
    .running       (frameRunning)
  );

  tdm_ser_dp #(
    .MAX_WIDTH(MAX_WIDTH)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .smpWidthQ (smpWidthQ),
    .fmtQ      (fmtQ),
    .monoQ     (monoQ),
    .lsbFirstQ (lsbFirstQ),
    .fifoData  (fifoData),
    .fifoEmpty (fifoEmpty),
    .fifoPop   (fifoPop),
    .sdOut     (sdOut),
    .underflow (underflow)
  );

endmodule

// File: rtl/tdm_ser_checker.sv
module tdm_ser_checker (
  input logic clk,
  input logic rstN,
  input logic bckEn,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic wsOut,
  input logic sdOut,
  input logic underflow,
  input logic running,
  input logic slotOn
);

  // R14: a pop happens only on a bit strobe of a running frame
  assert_pop_on_strobe_R14: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (bckEn && running));

  // R14: serial outputs hold between bit strobes
  assert_outputs_hold_R14: assert property (@(posedge clk) disable iff (!rstN)
    !bckEn |=> ($stable(wsOut) && $stable(sdOut)));

  // R11: never pop an empty FIFO
  assert_no_empty_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  // R11: the underflow flag is sticky
  assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

  // R9: a disabled slot never consumes a sample
  assert_masked_no_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> slotOn);

endmodule

bind tdm_frame_serializer tdm_ser_checker u_check (
  .clk      (clk),
  .rstN     (rstN),
  .bckEn    (bckEn),
  .fifoEmpty(fifoEmpty),
  .fifoPop  (fifoPop),
  .wsOut    (wsOut),
  .sdOut    (sdOut),
  .underflow(underflow),
  .running  (frameRunning),
  .slotOn   (strb.slotOn)
);

// File: tb/test_tdm_frame_serializer.sv
module test_tdm_frame_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_SLOTS  = 8;
  localparam int MAX_WIDTH  = 32;

  typedef struct {
    int          slots;
    int          sw;
    int          smpw;
    int          fmt;
    logic [7:0]  mask;
    bit          mono;
    bit          lsb;
  } tcfg_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bckEn = 1'b0;
  logic        runEn = 1'b0;
  logic [3:0]  cfgSlots = 4'd2;
  logic [5:0]  cfgSlotWidth = 6'd16;
  logic [5:0]  cfgSampleWidth = 6'd16;
  logic [1:0]  cfgFormat = 2'd0;
  logic [7:0]  cfgChanMask = 8'hFF;
  logic        cfgMono = 1'b0;
  logic        cfgLsbFirst = 1'b0;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoPop;
  logic        wsOut;
  logic        sdOut;
  logic        underflow;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  // Bench FIFO model
  logic [31:0] q [0:63];
  int popCnt = 0;
  int base = 0;
  int avail = 0;
  logic expUnd = 1'b0;
  logic lastWs = 1'b0;
  logic lastSd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (fifoPop) popCnt <= popCnt + 1;
  assign fifoEmpty = (popCnt - base) >= avail;
  assign fifoData  = q[(popCnt - base) & 63];

  tdm_frame_serializer #(.MAX_SLOTS(MAX_SLOTS), .MAX_WIDTH(MAX_WIDTH)) i_tdm_frame_serializer (
    .clk(clk), .rstN(rstN), .bckEn(bckEn), .runEn(runEn),
    .cfgSlots(cfgSlots), .cfgSlotWidth(cfgSlotWidth), .cfgSampleWidth(cfgSampleWidth),
    .cfgFormat(cfgFormat), .cfgChanMask(cfgChanMask), .cfgMono(cfgMono),
    .cfgLsbFirst(cfgLsbFirst), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoPop(fifoPop), .wsOut(wsOut), .sdOut(sdOut), .underflow(underflow));

  task automatic check(string req, string what, int f, int p, logic act, logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s frame %0d pos %0d: got %b expected %b", req, what, f, p, act, exp);
    end
  endtask

  task automatic checkInt(string req, string what, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wsWidthOf(tcfg_t c);
    case (c.fmt)
      2: return 1;
      3: return c.sw;
      default: return c.slots * c.sw / 2;
    endcase
  endfunction

  function automatic logic openOf(tcfg_t c);
    return (c.slots > 2);
  endfunction

  function automatic logic expWsAt(tcfg_t c, int p);
    return (p < wsWidthOf(c)) ? openOf(c) : !openOf(c);
  endfunction

  function automatic logic expBitAt(tcfg_t c, logic [31:0] w, int b);
    if (b >= c.smpw) return 1'b0;
    return c.lsb ? w[b] : w[c.smpw - 1 - b];
  endfunction

  function automatic tcfg_t mk(int slots, int sw, int smpw, int fmt,
                               logic [7:0] mask, bit mono, bit lsb);
    tcfg_t c;
    c.slots = slots; c.sw = sw; c.smpw = smpw; c.fmt = fmt;
    c.mask = mask; c.mono = mono; c.lsb = lsb;
    return c;
  endfunction

  function automatic tcfg_t randCfg();
    tcfg_t c;
    c.slots = int'($urandom_range(8, 2));
    c.sw    = int'($urandom_range(32, 2));
    c.smpw  = int'($urandom_range(c.sw, 1));
    c.fmt   = int'($urandom_range(3, 0));
    c.mask  = 8'($urandom()) | 8'h03;
    c.mono  = ($urandom_range(3, 0) == 0);
    c.lsb   = $urandom_range(1, 0) == 1;
    return c;
  endfunction

  task automatic applyCfg(tcfg_t c);
    cfgSlots = 4'(c.slots);
    cfgSlotWidth = 6'(c.sw);
    cfgSampleWidth = 6'(c.smpw);
    cfgFormat = 2'(c.fmt);
    cfgChanMask = c.mask;
    cfgMono = c.mono;
    cfgLsbFirst = c.lsb;
  endtask

  // One bit period: a quiet edge, then a strobed edge; returns at the
  // falling edge after the strobed edge.
  task automatic tick();
    @(negedge clk);
    check("R14", "ws held without strobe", -1, -1, wsOut, lastWs);
    check("R14", "sd held without strobe", -1, -1, sdOut, lastSd);
    bckEn = 1'b1;
    @(negedge clk);
    bckEn = 1'b0;
    lastWs = wsOut;
    lastSd = sdOut;
  endtask

  task automatic runCase(string req, tcfg_t a, tcfg_t b, int nFrames, int nAvail);
    tcfg_t c;
    int expIdx = 0;
    logic prevRaw = 1'b0;
    logic raw;
    logic [31:0] w = '0;
    logic [31:0] monoW = '0;
    int fb;
    int s;
    int bi;
    base = popCnt;
    avail = nAvail;
    for (int i = 0; i < 64; i++) q[i] = $urandom();
    c = a;
    applyCfg(a);
    runEn = 1'b1;
    tick();  // frame start is accepted here
    for (int f = 0; f < nFrames; f++) begin
      c = (f == 0) ? a : b;
      fb = c.slots * c.sw;
      for (int p = 0; p < fb; p++) begin
        s = p / c.sw;
        bi = p % c.sw;
        if (bi == 0) begin
          if (!c.mask[s]) w = '0;
          else if (c.mono && s != 0) w = monoW;
          else if (expIdx < nAvail) begin w = q[expIdx]; expIdx++; end
          else begin w = '0; expUnd = 1'b1; end
          if (s == 0) monoW = w;
        end
        raw = expBitAt(c, w, bi);
        tick();
        check(req, "ws", f, p, wsOut, expWsAt(c, p));
        check(req, "sd", f, p, sdOut, (c.fmt == 0) ? prevRaw : raw);
        prevRaw = raw;
        if (f == 0 && nFrames > 1 && p == fb / 2) applyCfg(b);  // R12
        if (f == nFrames - 1 && p == 0) runEn = 1'b0;
      end
    end
    tick();
    check("R13", "idle ws", nFrames, 0, wsOut, openOf(c));
    check("R13 R6", "trailing sd", nFrames, 0, sdOut, (c.fmt == 0) ? prevRaw : 1'b0);
    tick();
    check("R13", "idle ws", nFrames, 1, wsOut, openOf(c));
    check("R13", "idle sd", nFrames, 1, sdOut, 1'b0);
    checkInt({req, " R9 R10"}, "pop count", popCnt - base, expIdx);
    check("R11", "underflow flag", -1, -1, underflow, expUnd);
  endtask

  initial begin
    tcfg_t a;
    tcfg_t b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset ws", -1, -1, wsOut, 1'b0);
    check("R1", "reset sd", -1, -1, sdOut, 1'b0);
    check("R1", "reset pop", -1, -1, fifoPop, 1'b0);
    check("R1", "reset underflow", -1, -1, underflow, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    tick();
    check("R1", "idle ws after reset", -1, -1, wsOut, 1'b0);

    a = mk(2, 16, 16, 0, 8'h03, 0, 0);
    runCase("R2 R6 standard 2x16", a, a, 2, 64);
    a = mk(2, 32, 24, 1, 8'h03, 0, 0);
    runCase("R2 R7 left-justified 2x32/24", a, a, 2, 64);
    a = mk(4, 16, 12, 2, 8'h0F, 0, 0);
    runCase("R3 R5 short pulse 4x16", a, a, 2, 64);
    a = mk(8, 8, 8, 3, 8'hFF, 0, 1);
    runCase("R4 R5 R8 long pulse 8x8 lsb-first", a, a, 2, 64);
    a = mk(4, 16, 16, 1, 8'b1011, 0, 0);
    runCase("R9 slot mask", a, a, 2, 64);
    a = mk(4, 16, 16, 3, 8'b0111, 1, 0);
    runCase("R10 mono", a, a, 3, 64);
    a = mk(2, 16, 16, 0, 8'h03, 0, 0);
    b = mk(4, 8, 5, 3, 8'h0F, 0, 1);
    runCase("R12 config at boundary", a, b, 3, 64);
    a = mk(2, 2, 1, 2, 8'h03, 0, 0);
    runCase("R3 R7 minimal slots", a, a, 2, 64);

    for (int k = 0; k < 25; k++) begin
      a = randCfg();
      b = (k % 3 == 0) ? randCfg() : a;
      runCase("R2 R12 random", a, b, 1 + (k % 3), 64);
    end

    a = mk(4, 8, 8, 1, 8'h0F, 0, 0);
    runCase("R11 underflow", a, a, 1, 3);
    a = mk(2, 8, 8, 1, 8'h03, 0, 0);
    runCase("R11 underflow stays set", a, a, 1, 64);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule